// File: doc/BRIEF.md
# Chien Search Error Location Engine

This block locates the bit errors in a sector once an error locator polynomial has been computed upstream. Software loads the coefficients of sigma into a bank of registers, writes a configuration word that chooses the Galois field and the number of coefficients in use, and then writes a start word that carries the number of bit positions to scan (data bits plus parity bits). The engine tests one candidate position per clock by evaluating sigma at successive powers of the primitive element. Each root it finds is recorded as a 1-based bit position.

When the scan ends, a done flag rises together with the number of roots found. Software compares that count with the degree of sigma. If they match, the sector is correctable: for each stored value v, software flips bit (v-1) mod 8 of byte (v-1)/8. If they differ, the sector holds too many errors. A maskable interrupt follows the done flag. All control and status use plain register reads and writes, with no streaming path. A write takes effect on the clock edge where `wr_en` is high. `rdata` is combinational from `addr`. `rd_en` marks a read that has side effects.

Top module: `chien_locator`

## Requirements
- R1: The configuration register at address 0 holds the field select in bit 0 and the number of coefficients minus one (n) in bits 20:16. A field select of 0 means GF(2^13) with polynomial 0x201B, for 512-byte sectors. A field select of 1 means GF(2^14) with polynomial 0x4443, for 1024-byte sectors. Coefficient registers above index n are ignored by the search.
- R2: Writing L to address 1 starts a search. Bit 0 of the status register (address 3) reads 1 from the cycle after the write. The engine tests one candidate per clock, with candidate k (0-based) testing sigma(alpha^k). Busy clears and done sets exactly L clock edges after the start edge.
- R3: A root at alpha^(v-1) is reported as the value v. Values are stored in ascending order in the location registers at addresses 40, 41, and onward.
- R4: The status word at address 7 carries done in bit 0 and the root count in bits 12:8. The count equals the number of roots whose value v lies in 1..L. Roots beyond L are neither counted nor stored.
- R5: A read of address 7 with `rd_en` high clears done. The root count and the stored locations keep their values until the next start.
- R6: Only the first 24 roots are stored. The count saturates at 31.
- R7: Writing 1 in bit 0 to address 2 clears busy on the next edge without setting done. Coefficients written to addresses 8 through 32 (index = address - 8) may then be reloaded.
- R8: Writing 1 in bit 0 to address 4 sets the interrupt mask, and doing the same at address 5 clears it. Address 6 reads the mask in bit 0. `irq` equals done AND mask.
- R9: A start with L = 0 sets done on the start edge itself and reports a count of zero.
- R10: After reset, status, mask, done, count and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for side effects) |
| addr | input | 6 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Done interrupt, masked |

## Verification
The hardest case to reach is count saturation, because it needs more than 31 roots inside one scan. A real polynomial of low degree can never produce that. The bench reaches it by loading an all-zero sigma with a single coefficient, which makes every candidate a root. A second hard case is a root at exactly position L next to one at L+1, which shows where the scan ends. Both fields are swept over polynomial degrees 1 to 6, with roots built in the bench as products of linear factors.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int SYM_W = 14;
  localparam logic [SYM_W:0] POLY13 = 15'h201B;
  localparam logic [SYM_W:0] POLY14 = 15'h4443;

  // one step: multiply by the primitive element in the selected field
  function automatic logic [SYM_W-1:0] mul_alpha(logic [SYM_W-1:0] v, logic wide);
    logic [SYM_W:0] s;
    s = {v, 1'b0};
    if (wide) begin
      if (s[14]) s = s ^ POLY14;
    end else begin
      if (s[13]) s = s ^ POLY13;
    end
    return s[SYM_W-1:0];
  endfunction

  // multiply by alpha^n, n small and constant at each call site
  function automatic logic [SYM_W-1:0] mul_alpha_pow(logic [SYM_W-1:0] v, logic wide, int n);
    logic [SYM_W-1:0] a;
    a = v;
    for (int i = 0; i < 32; i++)
      if (i < n) a = mul_alpha(a, wide);
    return a;
  endfunction
endpackage

// File: rtl/chien_core.sv
module chien_core
  import chien_pkg::*;
#(
  parameter int NCOEF = 25,
  parameter int LEN_W = 16,
  localparam int NC_W = $clog2(NCOEF)
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       stop,
  input  logic                       wide,
  input  logic [NC_W-1:0]            ncoef_m1,
  input  logic [LEN_W-1:0]           len,
  input  logic [NCOEF-1:0][SYM_W-1:0] sigma_in,
  output logic                       busy,
  output logic                       hit,
  output logic [LEN_W-1:0]           pos,
  output logic                       finish
);
  logic [SYM_W-1:0] term [NCOEF];
  logic [LEN_W-1:0] k_q, last_q;
  logic             wide_q;
  logic [SYM_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int j = 0; j < NCOEF; j++) sum = sum ^ term[j];
  end

  assign hit    = busy && (sum == '0);
  assign pos    = k_q + 1'b1;
  assign finish = busy && (k_q == last_q);

  for (genvar j = 0; j < NCOEF; j++) begin : g_term
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        term[j] <= '0;
      else if (start)
        term[j] <= (NC_W'(j) <= ncoef_m1) ? sigma_in[j] : '0;
      else if (busy)
        term[j] <= mul_alpha_pow(term[j], wide_q, j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      k_q    <= '0;
      last_q <= '0;
      wide_q <= 1'b0;
    end else if (start) begin
      busy   <= (len != '0);
      k_q    <= '0;
      last_q <= len - 1'b1;
      wide_q <= wide;
    end else if (stop) begin
      busy <= 1'b0;
    end else if (busy) begin
      k_q <= k_q + 1'b1;
      if (k_q == last_q) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/root_store.sv
module root_store #(
  parameter int NLOC  = 24,
  parameter int LEN_W = 16,
  parameter int CNT_W = 5,
  localparam int CNT_MAX = (1 << CNT_W) - 1
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       hit,
  input  logic [LEN_W-1:0]           pos,
  output logic [CNT_W-1:0]           cnt,
  output logic [NLOC-1:0][LEN_W-1:0] loc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      loc <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (hit) begin
      if (int'(cnt) < NLOC) loc[cnt] <= pos;
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chien_locator.sv
module chien_locator
  import chien_pkg::*;
#(
  parameter int NCOEF  = 25,
  parameter int NLOC   = 24,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int NC_W  = $clog2(NCOEF)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(7);
  localparam int A_SIG = 8;
  localparam int A_LOC = 40;

  logic                        wide_sel, irq_mask, done;
  logic [NC_W-1:0]             ncoef_m1;
  logic [NCOEF-1:0][SYM_W-1:0] sig;
  logic                        busy, hit, finish;
  logic [LEN_W-1:0]            pos;
  logic [CNT_W-1:0]            root_cnt;
  logic [NLOC-1:0][LEN_W-1:0]  loc;

  wire start_wr = wr_en && (addr == A_START);
  wire stop_wr  = wr_en && (addr == A_STOP) && wdata[0];
  wire isr_rd   = rd_en && (addr == A_ISR);
  wire unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_sel <= 1'b0;
      ncoef_m1 <= '0;
      irq_mask <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CFG) begin
        wide_sel <= wdata[0];
        ncoef_m1 <= wdata[16 +: NC_W];
      end
      if (addr == A_IEN && wdata[0])  irq_mask <= 1'b1;
      if (addr == A_IDIS && wdata[0]) irq_mask <= 1'b0;
    end
  end

  for (genvar j = 0; j < NCOEF; j++) begin : g_sig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sig[j] <= '0;
      else if (wr_en && addr == ADDR_W'(A_SIG + j))
        sig[j] <= wdata[SYM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (start_wr) done <= (wdata[LEN_W-1:0] == '0);
    else if (finish)   done <= 1'b1;
    else if (isr_rd)   done <= 1'b0;
  end

  assign irq = done && irq_mask;

  chien_core #(.NCOEF(NCOEF), .LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .stop(stop_wr),
    .wide(wide_sel), .ncoef_m1(ncoef_m1), .len(wdata[LEN_W-1:0]),
    .sigma_in(sig), .busy(busy), .hit(hit), .pos(pos), .finish(finish)
  );

  root_store #(.NLOC(NLOC), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(start_wr), .hit(hit), .pos(pos),
    .cnt(root_cnt), .loc(loc)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:  begin rdata[0] = wide_sel; rdata[16 +: NC_W] = ncoef_m1; end
      A_STAT: rdata[0] = busy;
      A_IMSK: rdata[0] = irq_mask;
      A_ISR:  begin rdata[0] = done; rdata[8 +: CNT_W] = root_cnt; end
      default: begin
        for (int i = 0; i < NLOC; i++)
          if (addr == ADDR_W'(A_LOC + i)) rdata[LEN_W-1:0] = loc[i];
      end
    endcase
  end
endmodule

// File: rtl/chien_locator_chk.sv
module chien_locator_chk #(
  parameter int CNT_W = 5
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start_wr,
  input logic             stop_wr,
  input logic             isr_rd,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic [CNT_W-1:0] root_cnt
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !start_wr) |=> !busy); // R7
  AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (root_cnt == '0) && !$past(isr_rd && done && !start_wr)); // R4
  AST_CNT_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_wr) |=> (root_cnt >= $past(root_cnt))); // R6
  AST_ISR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !busy && !start_wr) |=> !done); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R8
endmodule

bind chien_locator chien_locator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
  .isr_rd(isr_rd), .busy(busy), .done(done), .irq(irq), .root_cnt(root_cnt)
);

// File: tb/tb_chien_locator.sv
`timescale 1ns/1ps
module tb_chien_locator;
  localparam int A_CFG = 0, A_START = 1, A_STOP = 2, A_STAT = 3;
  localparam int A_IEN = 4, A_IDIS = 5, A_IMSK = 6, A_ISR = 7;
  localparam int A_SIG = 8, A_LOC = 40;

  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;

  chien_locator dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = a[5:0]; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = a[5:0]; rd_en = 1; #1 d = int'(rdata);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(int a, output int d);
    addr = a[5:0]; #1 d = int'(rdata);
  endtask

  function automatic int gmul(int a, int b, bit wide);
    int p = 0, x = a;
    int m = wide ? 14 : 13;
    int poly = wide ? 'h4443 : 'h201B;
    for (int i = 0; i < 14; i++) begin
      if ((b >> i) & 1) p = p ^ x;
      x = x << 1;
      if ((x >> m) & 1) x = x ^ poly;
    end
    return p;
  endfunction

  function automatic int apow(int n, bit wide);
    int v = 1;
    for (int i = 0; i < n; i++) v = gmul(v, 2, wide);
    return v;
  endfunction

  task automatic wait_idle();
    int s;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk); peek(A_STAT, s);
      if ((s & 1) == 0) break;
    end
  endtask

  // roots ascending; sigma = prod (x + alpha^(v-1))
  task automatic run_case(bit wide, int roots[8], int nr, int lenv, int junk, string tag);
    int c[26];
    int v, expn;
    for (int j = 0; j < 26; j++) c[j] = 0;
    c[0] = 1;
    for (int r = 0; r < nr; r++) begin
      int a = apow(roots[r] - 1, wide);
      for (int j = r + 1; j >= 1; j--) c[j] = c[j-1] ^ gmul(a, c[j], wide);
      c[0] = gmul(a, c[0], wide);
    end
    wr(A_STOP, 1);
    for (int j = 0; j < 25; j++) wr(A_SIG + j, (j <= nr) ? c[j] : junk);
    wr(A_CFG, (nr << 16) | int'(wide));
    wr(A_START, lenv);
    wait_idle();
    expn = 0;
    for (int r = 0; r < nr; r++) if (roots[r] <= lenv) expn++;
    rd(A_ISR, v);
    chk((v & 1) == 1, {tag, " R2 done"}, v & 1, 1);
    chk(((v >> 8) & 31) == expn, {tag, " R4 count"}, (v >> 8) & 31, expn);
    for (int i = 0; i < expn; i++) begin
      rd(A_LOC + i, v);
      chk(v == roots[i], {tag, " R3 location"}, v, roots[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    peek(A_STAT, v); chk(v == 0, "R10 status", v, 0);
    peek(A_ISR, v);  chk(v == 0, "R10 isr", v, 0);
    peek(A_IMSK, v); chk(v == 0, "R10 mask", v, 0);
    chk(irq == 0, "R10 irq", int'(irq), 0);

    // R2 exact timing: sigma = 1, no roots, L = 10
    wr(A_SIG, 1); wr(A_CFG, 0); wr(A_START, 10);
    peek(A_STAT, v); chk(v == 1, "R2 busy after start", v, 1);
    repeat (9) @(negedge clk);
    peek(A_STAT, v); chk(v == 1, "R2 busy at edge 9", v, 1);
    @(negedge clk);
    peek(A_STAT, v); chk(v == 0, "R2 idle at edge 10", v, 0);
    peek(A_ISR, v);  chk(v == 1, "R2 done no roots", v, 1);

    // R9 zero length
    wr(A_START, 0);
    peek(A_ISR, v); chk(v == 1, "R9 zero length done", v, 1);

    // R1/R3/R4 sweep over both fields and degrees
    for (int w = 0; w < 2; w++)
      for (int d = 1; d <= 6; d++)
        for (int s = 0; s < 2; s++) begin
          int rr[8];
          for (int i = 0; i < 8; i++) rr[i] = 1 + s * 7 + i * 29;
          run_case(w[0], rr, d, 200, 0, w ? "R1 wide sweep" : "R1 narrow sweep");
        end

    // R4 boundary: root at L counted, L+1 not (count 3 vs degree 4)
    run_case(1'b0, '{1, 60, 120, 121, 0, 0, 0, 0}, 4, 120, 0, "R4 boundary");
    // R5: second read shows done cleared, count kept
    rd(A_ISR, v);
    chk((v & 1) == 0, "R5 done cleared", v & 1, 0);
    chk(((v >> 8) & 31) == 3, "R5 count kept", (v >> 8) & 31, 3);

    // R1 coefficients above n ignored
    run_case(1'b1, '{4, 9, 0, 0, 0, 0, 0, 0}, 2, 50, 'h1ABC, "R1 junk ignored");

    // R6 saturation: sigma = 0 makes every position a root
    wr(A_STOP, 1); wr(A_SIG, 0); wr(A_CFG, 0); wr(A_START, 40);
    wait_idle();
    rd(A_ISR, v); chk(((v >> 8) & 31) == 31, "R6 count saturates", (v >> 8) & 31, 31);
    for (int i = 0; i < 24; i++) begin
      rd(A_LOC + i, v); chk(v == i + 1, "R6 stored location", v, i + 1);
    end

    // R7 stop
    wr(A_START, 5000);
    repeat (20) @(negedge clk);
    wr(A_STOP, 1);
    peek(A_STAT, v); chk(v == 0, "R7 stopped", v, 0);
    repeat (10) @(negedge clk);
    peek(A_ISR, v); chk((v & 1) == 0, "R7 no done", v & 1, 0);

    // R8 interrupt
    wr(A_IEN, 1);
    peek(A_IMSK, v); chk(v == 1, "R8 mask set", v, 1);
    wr(A_START, 5); wait_idle();
    chk(irq == 1, "R8 irq asserted", int'(irq), 1);
    rd(A_ISR, v);
    chk(irq == 0, "R8 irq cleared by read", int'(irq), 0);
    wr(A_IDIS, 1);
    peek(A_IMSK, v); chk(v == 0, "R8 mask cleared", v, 0);
    wr(A_START, 5); wait_idle();
    chk(irq == 0, "R8 irq masked", int'(irq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule